// File: doc/BRIEF.md
# Video Sync Level Measurement Unit

This block watches a stream of digitized composite video, one 7-bit sample per ADC clock, together with a horizontal sync line. It produces three results. The first is the pedestal (back porch) level: the sample taken a programmable number of clocks after each rising edge of horizontal sync. The second is the sync-tip level: the smallest sample found inside a programmable window of the line. The third is a composite sync bit, formed by slicing each sample against a programmable threshold.

The three results drive the block's output pins directly. Software can also read them through a small register port, and it sets the capture offset, the window bounds and the slicer threshold through the same port. A clamp loop elsewhere would use the pedestal and the sync-tip values to steer the video DC level.

Top module: `vslm_top`

## Requirements
- R1: After reset, pedestal, sync-tip minimum and sync bit read 0. The window start, window end and threshold registers read 0, and the capture offset register reads 0x03C.
- R2: A line starts only on a 0-to-1 change of `hsync_i`. While `hsync_i` stays high no new line starts, and each later rise starts a new line.
- R3: The sample that arrives with the rising edge is offset 0 of the line. The sample at offset equal to the capture offset register (address 0, bits [8:0]) is stored as the pedestal, which appears on `ped_o` two clocks after that sample is presented.
- R4: If no line starts, `ped_o` keeps its value.
- R5: The offset counts up to 0x1FF and then stops. Offset 0x1FF can be captured, and no capture happens after it until the next rise.
- R6: With window start at address 1 and window end at address 2 (bits [8:0]), `sync_min_o` takes the minimum of the samples at offsets start..end inclusive. It updates two clocks after the end-offset sample and holds otherwise. If end < start, it never updates.
- R7: `csync_o` is 1 exactly when the sample is below the zero-extended 6-bit threshold at address 3, bits [5:0], two clocks after the sample is presented.
- R8: Register reads return, one clock after the address is presented, the zero-extended value held before that clock. The addresses are: 0 capture offset, 1 window start, 2 window end, 3 threshold, 4 pedestal, 5 sync-tip minimum. Written bits above each field's width are dropped. A write takes effect for the sample presented in the same clock.
- R9: A rise during a line restarts the offset at 0, so a capture still pending on the earlier line does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync indication |
| sample_i | input | 7 | Digitized video sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| ped_o | output | 7 | Captured pedestal level |
| sync_min_o | output | 7 | Sync-tip minimum of the last window |
| csync_o | output | 1 | Sliced composite sync |

## Verification
The hardest states to reach are the far end of the line counter, where offset 0x1FF must be captured once and the counter must then stay quiet, and a second rise of sync that cuts into a line before its capture offset is reached. Directed lines reach both: one holds sync high for more than 512 clocks with a known sample ramp, and another drops and raises sync three clocks into a line. Random lines with random sync periods and occasional register writes then run against a cycle-level model of the requirements.

// File: rtl/vslm_pkg.sv
package vslm_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADR_POS    = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_WSTART = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_WEND   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_THR    = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_PED    = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADR_MIN    = 3'd5;
endpackage

// File: rtl/vslm_regs.sv
module vslm_regs
  import vslm_pkg::*;
#(
  parameter int unsigned SMP_W   = 7,
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned THR_W   = 6,
  parameter int unsigned DATA_W  = 16,
  parameter logic [CNT_W-1:0] POS_RST = 9'h03C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [SMP_W-1:0]      ped_i,
  input  logic [SMP_W-1:0]      min_i,
  output logic [CNT_W-1:0]      pos_o,
  output logic [CNT_W-1:0]      wstart_o,
  output logic [CNT_W-1:0]      wend_o,
  output logic [THR_W-1:0]      thr_o,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_o    <= POS_RST;
      wstart_o <= '0;
      wend_o   <= '0;
      thr_o    <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADR_POS:    pos_o    <= wdata_i[CNT_W-1:0];
        ADR_WSTART: wstart_o <= wdata_i[CNT_W-1:0];
        ADR_WEND:   wend_o   <= wdata_i[CNT_W-1:0];
        ADR_THR:    thr_o    <= wdata_i[THR_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADR_POS:    rd_mux[CNT_W-1:0] = pos_o;
      ADR_WSTART: rd_mux[CNT_W-1:0] = wstart_o;
      ADR_WEND:   rd_mux[CNT_W-1:0] = wend_o;
      ADR_THR:    rd_mux[THR_W-1:0] = thr_o;
      ADR_PED:    rd_mux[SMP_W-1:0] = ped_i;
      ADR_MIN:    rd_mux[SMP_W-1:0] = min_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end
endmodule

// File: rtl/vslm_linecnt.sv
module vslm_linecnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_i,
  output logic             hs_q_o,
  output logic             line_edge_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_valid_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic             hs_q2;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q_o <= 1'b0;
      hs_q2  <= 1'b0;
    end else begin
      hs_q_o <= hsync_i;
      hs_q2  <= hs_q_o;
    end
  end

  assign line_edge_o = hs_q_o & ~hs_q2;
  assign cnt_o       = line_edge_o ? '0 : cnt_q + 1'b1;
  assign cnt_valid_o = line_edge_o | armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_valid_o) cnt_q <= cnt_o;
      armed_q <= cnt_valid_o && (cnt_o != CNT_LAST);
    end
  end
endmodule

// File: rtl/vslm_measure.sv
module vslm_measure #(
  parameter int unsigned SMP_W = 7,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_valid_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] wstart_i,
  input  logic [CNT_W-1:0] wend_i,
  output logic [SMP_W-1:0] ped_o,
  output logic [SMP_W-1:0] min_o
);
  localparam logic [SMP_W-1:0] SMP_MAX = '1;

  logic             cap_hit;
  logic             in_win;
  logic             at_start;
  logic             at_end;
  logic [SMP_W-1:0] trk_q;
  logic [SMP_W-1:0] base;
  logic [SMP_W-1:0] cand;

  assign cap_hit  = cnt_valid_i && (cnt_i == pos_i);
  assign in_win   = cnt_valid_i && (cnt_i >= wstart_i) && (cnt_i <= wend_i);
  assign at_start = (cnt_i == wstart_i);
  assign at_end   = (cnt_i == wend_i);
  assign base     = at_start ? SMP_MAX : trk_q;
  assign cand     = (smp_i < base) ? smp_i : base;

  always_ff @(posedge clk) begin
    if (rst) ped_o <= '0;
    else if (cap_hit) ped_o <= smp_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_q <= SMP_MAX;
      min_o <= '0;
    end else if (in_win) begin
      trk_q <= cand;
      if (at_end) min_o <= cand;
    end
  end
endmodule

// File: rtl/vslm_slicer.sv
module vslm_slicer #(
  parameter int unsigned SMP_W = 7,
  parameter int unsigned THR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             csync_o
);
  logic [SMP_W-1:0] thr_ext;

  always_comb begin
    thr_ext = '0;
    thr_ext[THR_W-1:0] = thr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) csync_o <= 1'b0;
    else     csync_o <= (smp_i < thr_ext);
  end
endmodule

// File: rtl/vslm_top.sv
module vslm_top
  import vslm_pkg::*;
#(
  parameter int unsigned SMP_W  = 7,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned DATA_W = 16,
  parameter logic [CNT_W-1:0] POS_RST = 9'h03C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hsync_i,
  input  logic [SMP_W-1:0]      sample_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [SMP_W-1:0]      ped_o,
  output logic [SMP_W-1:0]      sync_min_o,
  output logic                  csync_o
);
  logic [SMP_W-1:0] smp_q;
  logic             hs_q;
  logic             line_edge;
  logic [CNT_W-1:0] cnt;
  logic             cnt_valid;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] wstart;
  logic [CNT_W-1:0] wend;
  logic [THR_W-1:0] thr;

  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else     smp_q <= sample_i;
  end

  vslm_regs #(
    .SMP_W(SMP_W), .CNT_W(CNT_W), .THR_W(THR_W), .DATA_W(DATA_W), .POS_RST(POS_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ped_i(ped_o), .min_i(sync_min_o), .pos_o(pos), .wstart_o(wstart), .wend_o(wend),
    .thr_o(thr), .rdata_o(reg_rdata_o)
  );

  vslm_linecnt #(.CNT_W(CNT_W)) u_linecnt (
    .clk(clk), .rst(rst), .hsync_i(hsync_i), .hs_q_o(hs_q), .line_edge_o(line_edge),
    .cnt_o(cnt), .cnt_valid_o(cnt_valid)
  );

  vslm_measure #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_measure (
    .clk(clk), .rst(rst), .smp_i(smp_q), .cnt_i(cnt), .cnt_valid_i(cnt_valid),
    .pos_i(pos), .wstart_i(wstart), .wend_i(wend), .ped_o(ped_o), .min_o(sync_min_o)
  );

  vslm_slicer #(.SMP_W(SMP_W), .THR_W(THR_W)) u_slicer (
    .clk(clk), .rst(rst), .smp_i(smp_q), .thr_i(thr), .csync_o(csync_o)
  );
endmodule

// File: rtl/vslm_checker.sv
module vslm_checker
  import vslm_pkg::*;
#(
  parameter int unsigned SMP_W  = 7,
  parameter int unsigned CNT_W  = 9,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hs_q,
  input logic                  line_edge,
  input logic [CNT_W-1:0]      cnt,
  input logic                  cnt_valid,
  input logic [CNT_W-1:0]      pos,
  input logic [CNT_W-1:0]      wend,
  input logic [THR_W-1:0]      thr,
  input logic [SMP_W-1:0]      ped,
  input logic [SMP_W-1:0]      smin,
  input logic                  csync,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0]     rdata
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  AST_EDGE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    line_edge |-> (hs_q && !$past(hs_q))); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_valid) && $past(cnt) != CNT_LAST && !line_edge)
      |-> (cnt_valid && cnt == $past(cnt) + 1'b1)); // R9

  AST_CNT_STOP: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_valid) && $past(cnt) == CNT_LAST && !line_edge) |-> !cnt_valid); // R5

  AST_PED_ONLY_AT_POS: assert property (@(posedge clk) disable iff (rst)
    !$stable(ped) |-> $past(cnt_valid && cnt == pos)); // R3

  AST_MIN_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(smin) |-> $past(cnt_valid && cnt == wend)); // R6

  AST_CSYNC_ZERO_THR: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |=> !csync); // R7

  AST_READ_PED: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADR_PED) |=>
      (rdata[SMP_W-1:0] == $past(ped) && rdata[DATA_W-1:SMP_W] == '0)); // R8
endmodule

bind vslm_top vslm_checker #(
  .SMP_W(SMP_W), .CNT_W(CNT_W), .THR_W(THR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .hs_q(hs_q), .line_edge(line_edge), .cnt(cnt),
  .cnt_valid(cnt_valid), .pos(pos), .wend(wend), .thr(thr), .ped(ped_o),
  .smin(sync_min_o), .csync(csync_o), .reg_addr(reg_addr_i), .rdata(reg_rdata_o)
);

// File: tb/test_vslm_top.sv
`timescale 1ns/1ps
module test_vslm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_i = 1'b0;
  logic [6:0]  sample_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [6:0]  ped_o;
  logic [6:0]  sync_min_o;
  logic        csync_o;

  int total = 0;
  int bad = 0;
  string ptag = "R3";

  vslm_top i_vslm_top (
    .clk(clk), .rst(rst), .hsync_i(hsync_i), .sample_i(sample_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ped_o(ped_o), .sync_min_o(sync_min_o), .csync_o(csync_o)
  );

  always #10 clk = ~clk;

  // requirement model
  int         m_cnt;
  bit         m_valid, m_prev, m_cs;
  logic [6:0] m_trk, m_ped, m_min;
  logic [8:0] m_pos, m_ws, m_we;
  logic [5:0] m_thr;

  task automatic model_reset();
    m_cnt = 0; m_valid = 0; m_prev = 0; m_cs = 0;
    m_trk = 7'h7f; m_ped = 0; m_min = 0;
    m_pos = 9'h03C; m_ws = 0; m_we = 0; m_thr = 0;
  endtask

  function automatic logic [6:0] min7(logic [6:0] a, logic [6:0] b);
    return (a < b) ? a : b;
  endfunction

  task automatic model_step(bit hs, logic [6:0] s, bit we, logic [2:0] a, logic [15:0] d);
    bit rise, cv;
    int cur;
    logic [6:0] mn;
    if (we) begin
      case (a)
        3'd0: m_pos = d[8:0];
        3'd1: m_ws  = d[8:0];
        3'd2: m_we  = d[8:0];
        3'd3: m_thr = d[5:0];
        default: ;
      endcase
    end
    rise = hs && !m_prev;
    m_prev = hs;
    cv = rise || m_valid;
    cur = rise ? 0 : m_cnt + 1;
    if (cv) begin
      if (cur == int'(m_pos)) m_ped = s;
      if (cur >= int'(m_ws) && cur <= int'(m_we)) begin
        mn = min7(s, (cur == int'(m_ws)) ? 7'h7f : m_trk);
        m_trk = mn;
        if (cur == int'(m_we)) m_min = mn;
      end
      m_cnt = cur;
    end
    m_valid = cv && (cur != 511);
    m_cs = (s < {1'b0, m_thr});
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // one ADC clock: drive, advance, compare outputs due from the previous tick
  task automatic tick(bit hs, logic [6:0] s, bit we = 0, logic [2:0] a = 0, logic [15:0] d = 0);
    logic [6:0] p_ped, p_min;
    bit p_cs;
    hsync_i = hs; sample_i = s; reg_wr_i = we; reg_addr_i = a; reg_wdata_i = d;
    p_ped = m_ped; p_min = m_min; p_cs = m_cs;
    model_step(hs, s, we, a, d);
    @(posedge clk);
    @(negedge clk);
    check(ptag, {9'd0, ped_o}, {9'd0, p_ped});
    check("R6", {9'd0, sync_min_o}, {9'd0, p_min});
    check("R7", {15'd0, csync_o}, {15'd0, p_cs});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 7'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    tick(0, 7'd0, 1, a, d);
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
    tick(0, 7'd0, 0, a, 16'd0);
    check(tag, reg_rdata_o, exp);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'd1234));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    ptag = "R1";
    check("R1", {9'd0, ped_o}, 16'd0);
    check("R1", {9'd0, sync_min_o}, 16'd0);
    check("R1", {15'd0, csync_o}, 16'd0);
    rd("R1", 3'd0, 16'h003C);
    rd("R1", 3'd1, 16'h0000);
    rd("R1", 3'd2, 16'h0000);
    rd("R1", 3'd3, 16'h0000);

    // R8: upper bits dropped, readback one clock later
    wr(3'd3, 16'hFFFF);
    rd("R8", 3'd3, 16'h003F);
    wr(3'd0, 16'hFFFF);
    rd("R8", 3'd0, 16'h01FF);
    wr(3'd3, 16'h0000);

    // R3: capture at offset 5
    ptag = "R3";
    wr(3'd0, 16'd5);
    idle(2);
    for (int k = 0; k < 10; k++) tick(1, 7'(20 + k));
    idle(2);
    check("R3", {9'd0, ped_o}, 16'd25);

    // R2: held high does not restart, new rise does
    ptag = "R2";
    wr(3'd0, 16'd0);
    for (int k = 0; k < 6; k++) tick(1, 7'(40 + k));
    idle(2);
    check("R2", {9'd0, ped_o}, 16'd40);
    for (int k = 0; k < 3; k++) tick(1, 7'(50 + k));
    idle(2);
    check("R2", {9'd0, ped_o}, 16'd50);

    // R4: no edge, value held
    ptag = "R4";
    for (int k = 0; k < 600; k++) tick(0, 7'd99);
    check("R4", {9'd0, ped_o}, 16'd50);
    snap = 16'({9'd0, ped_o});
    rd("R8", 3'd4, snap);

    // R5: offset 0x1FF captured once, then counter stopped
    ptag = "R5";
    wr(3'd0, 16'h01FF);
    for (int k = 0; k < 530; k++) tick(1, 7'(k % 100));
    idle(2);
    check("R5", {9'd0, ped_o}, 16'd11);
    for (int k = 0; k < 100; k++) tick(1, 7'd77);
    check("R5", {9'd0, ped_o}, 16'd11);
    idle(3);

    // R9: second rise restarts the line before offset 10
    ptag = "R9";
    wr(3'd0, 16'd10);
    for (int k = 0; k < 20; k++) tick((k < 3) || (k >= 4), 7'(60 + k));
    idle(2);
    check("R9", {9'd0, ped_o}, 16'd74);
    idle(3);

    // R6: window 8..12, then a window with end below start
    ptag = "R3";
    wr(3'd1, 16'd8);
    wr(3'd2, 16'd12);
    for (int k = 0; k < 20; k++) begin
      logic [6:0] s;
      s = 7'd100;
      if (k == 7)  s = 7'd5;
      if (k == 9)  s = 7'd45;
      if (k == 10) s = 7'd30;
      if (k == 13) s = 7'd3;
      tick(k == 0, s);
    end
    idle(2);
    check("R6", {9'd0, sync_min_o}, 16'd30);
    rd("R8", 3'd5, 16'd30);
    wr(3'd1, 16'd20);
    wr(3'd2, 16'd15);
    for (int k = 0; k < 30; k++) tick(k == 0, 7'd2);
    idle(2);
    check("R6", {9'd0, sync_min_o}, 16'd30);

    // R7: slicer boundaries
    wr(3'd3, 16'd20);
    tick(0, 7'd19); tick(0, 7'd20);
    check("R7", {15'd0, csync_o}, 16'd1);
    tick(0, 7'd21);
    check("R7", {15'd0, csync_o}, 16'd0);
    wr(3'd3, 16'h003F);
    tick(0, 7'd62); tick(0, 7'd63);
    check("R7", {15'd0, csync_o}, 16'd1);
    tick(0, 7'd0);
    check("R7", {15'd0, csync_o}, 16'd0);

    // random lines with occasional register writes
    ptag = "R3";
    wr(3'd0, 16'd30);
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd40);
    for (int line = 0; line < 60; line++) begin
      int len;
      len = 40 + int'($urandom % 90);
      for (int k = 0; k < len; k++) begin
        bit we;
        logic [2:0] a;
        logic [15:0] d;
        we = ($urandom % 50) == 0;
        a  = 3'($urandom % 4);
        d  = 16'($urandom % 130);
        tick(k < 5, 7'($urandom % 128), we, a, d);
      end
    end
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule